// File: doc/BRIEF.md
# Posted-Write Core Port Target

This block is the target (slave) end of a point-to-point, synchronous request/response link between two cores. Each signal has exactly one driver. An initiator presents a 3-bit command with an address, and with write data when it writes. The target answers with a single-cycle accept strobe. Writes are posted: they are complete once accepted and never produce a response. Reads return a 3-bit response code and a data word on a separate response channel. The response comes a fixed, parameterised number of cycles later, so responses leave in the order the reads were accepted.

A small word-addressed storage array sits behind the port. Addresses at or above its depth are unmapped. A busy input lets the storage side defer acceptance, and the initiator keeps its request unchanged until it sees the accept strobe. Acceptance is decided by a three-state machine:

- `ST_IDLE` has no request pending. It takes transition `T_IDLE_GRANT` when a command arrives with busy low, and `T_IDLE_STALL` when a command arrives with busy high.
- `ST_STALL` holds a deferred request. It takes `T_STALL_GRANT` once busy falls, and `T_STALL_DROP` back to idle if the command vanishes.
- `ST_GRANT` drives the accept strobe for one cycle. It always returns to idle by `T_GRANT_IDLE`.

The transfer happens on the clock edge at which accept is high.

Top module: `core_port_slave`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it, accept is 0, the response code is 000 and the response data is 0. Reset clears every storage word to 0.
- R2: Accept is registered. It is high for exactly one cycle, in the cycle after an edge at which a non-idle command (any code other than 000) was present and busy was low. Busy high, or command 000, at an edge keeps accept low in the next cycle.
- R3: Command 001 (write) stores the write data at the address on the edge where accept is high, when the address is mapped. It never produces a response.
- R4: Command 010 (read) to a mapped address produces response code 001 with the stored word. The response is held for one cycle, LAT cycles after the accepting edge, where LAT is 1 to 4. With LAT=1 it appears right after that edge.
- R5: Read responses leave in the order the reads were accepted, and each accepted read produces exactly one response.
- R6: An address at or above DEPTH is unmapped. A read there returns code 011 with data 0, and a write there changes no storage word.
- R7: Reserved command codes (011 through 111) are accepted like any other non-idle command, but they change no storage and produce no response.
- R8: A request deferred by busy is performed exactly once when it is finally accepted. The initiator keeps command, address and data stable from the first cycle it presents them until accept.
- R9: Whenever the response code is 000 the response data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all signals sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_cmd_i | input | 3 | Command: 000 idle, 001 write, 010 read, others reserved |
| req_addr_i | input | ADDR_W | Word address of the request |
| req_wdata_i | input | DATA_W | Write data, valid with a write command |
| tgt_busy_i | input | 1 | Storage side busy; defers acceptance |
| req_accept_o | output | 1 | One-cycle accept strobe; the transfer occurs at the edge where it is high |
| rsp_code_o | output | 3 | Response: 000 none, 001 data valid, 011 error |
| rsp_data_o | output | DATA_W | Read data accompanying the response code |

## Verification
A stuck or wrongly stepping acceptance machine shows at the port one cycle after the edge at fault. Accept is then high after a busy edge, missing after a free one, or longer than a single cycle. A misloaded or misrouted response stage shows exactly LAT cycles after the accepting edge: the response is missing, duplicated, early, late or carries the wrong data. A storage word corrupted by a reserved, unmapped or stalled request stays hidden until a later read of that word returns it, so every such stimulus is followed by a read-back.

// File: rtl/cp_pkg.sv
package cp_pkg;

    // Command codes on the request channel
    localparam logic [2:0] CMD_IDLE  = 3'b000;
    localparam logic [2:0] CMD_WRITE = 3'b001;
    localparam logic [2:0] CMD_READ  = 3'b010;

    // Response codes on the response channel
    typedef enum logic [2:0] {
        RSP_NONE = 3'b000,
        RSP_DATA = 3'b001,
        RSP_ERR  = 3'b011
    } rsp_e;

    // Acceptance state machine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_GRANT = 2'd2
    } acc_state_e;

endpackage

// File: rtl/cp_req_fsm.sv
module cp_req_fsm
    import cp_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] cmd_i,
    input  logic       busy_i,
    output logic       accept_o,
    output logic       wr_fire_o,
    output logic       rd_fire_o
);

    acc_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_i != CMD_IDLE) begin
                    if (busy_i) state_d = ST_STALL;   // T_IDLE_STALL
                    else        state_d = ST_GRANT;   // T_IDLE_GRANT
                end
            end
            ST_STALL: begin
                if (cmd_i == CMD_IDLE) state_d = ST_IDLE;   // T_STALL_DROP
                else if (!busy_i)      state_d = ST_GRANT;  // T_STALL_GRANT
            end
            ST_GRANT: state_d = ST_IDLE;                    // T_GRANT_IDLE
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs: transfer happens at the edge where accept is high
    always_comb begin
        accept_o  = 1'b0;
        wr_fire_o = 1'b0;
        rd_fire_o = 1'b0;
        unique case (state_q)
            ST_GRANT: begin
                accept_o  = 1'b1;
                wr_fire_o = (cmd_i == CMD_WRITE);
                rd_fire_o = (cmd_i == CMD_READ);
            end
            ST_IDLE, ST_STALL: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/cp_store.sv
module cp_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16   // power of two, below 2**ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_fire_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              hit_o,
    output logic [DATA_W-1:0] rword_o
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CMP_W = ADDR_W + 1;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0]  idx;

    assign idx   = addr_i[IDX_W-1:0];
    assign hit_o = ({1'b0, addr_i} < CMP_W'(DEPTH));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_fire_i && hit_o) begin
            mem_q[idx] <= wdata_i;
        end
    end

    assign rword_o = hit_o ? mem_q[idx] : '0;

endmodule

// File: rtl/cp_resp_pipe.sv
module cp_resp_pipe
    import cp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LAT    = 2   // 1 to 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              hit_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [2:0]        code_o,
    output logic [DATA_W-1:0] data_o
);

    rsp_e              code_q [LAT];
    logic [DATA_W-1:0] data_q [LAT];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < LAT; i++) begin
                code_q[i] <= RSP_NONE;
                data_q[i] <= '0;
            end
        end else begin
            if (!load_i)    code_q[0] <= RSP_NONE;
            else if (hit_i) code_q[0] <= RSP_DATA;
            else            code_q[0] <= RSP_ERR;
            data_q[0] <= (load_i && hit_i) ? word_i : '0;
            for (int i = 1; i < LAT; i++) begin
                code_q[i] <= code_q[i-1];
                data_q[i] <= data_q[i-1];
            end
        end
    end

    assign code_o = code_q[LAT-1];
    assign data_o = data_q[LAT-1];

endmodule

// File: rtl/core_port_slave.sv
module core_port_slave
    import cp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int LAT    = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        req_cmd_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              tgt_busy_i,
    output logic              req_accept_o,
    output logic [2:0]        rsp_code_o,
    output logic [DATA_W-1:0] rsp_data_o
);

    logic              wr_fire, rd_fire, hit;
    logic [DATA_W-1:0] rword;

    cp_req_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cmd_i     (req_cmd_i),
        .busy_i    (tgt_busy_i),
        .accept_o  (req_accept_o),
        .wr_fire_o (wr_fire),
        .rd_fire_o (rd_fire)
    );

    cp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_fire_i (wr_fire),
        .addr_i    (req_addr_i),
        .wdata_i   (req_wdata_i),
        .hit_o     (hit),
        .rword_o   (rword)
    );

    cp_resp_pipe #(.DATA_W(DATA_W), .LAT(LAT)) u_pipe (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (rd_fire),
        .hit_i  (hit),
        .word_i (rword),
        .code_o (rsp_code_o),
        .data_o (rsp_data_o)
    );

endmodule

// File: rtl/cp_checker.sv
module cp_checker
    import cp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LAT    = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [2:0]        req_cmd_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic [DATA_W-1:0] req_wdata_i,
    input logic              tgt_busy_i,
    input logic              req_accept_o,
    input logic [2:0]        rsp_code_o,
    input logic [DATA_W-1:0] rsp_data_o
);

    a_r2_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(tgt_busy_i) |-> !req_accept_o);

    a_r2_idle_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(req_cmd_i == CMD_IDLE) |-> !req_accept_o);

    a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_accept_o |=> !req_accept_o);

    a_r4_resp_has_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_code_o != RSP_NONE) |-> $past(req_accept_o && req_cmd_i == CMD_READ, LAT));

    a_r5_read_has_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(req_accept_o && req_cmd_i == CMD_READ, LAT) |-> (rsp_code_o != RSP_NONE));

    a_r6_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_code_o == RSP_ERR) |-> (rsp_data_o == '0));

    a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(req_cmd_i != CMD_IDLE && !req_accept_o)
        |-> ($stable(req_cmd_i) && $stable(req_addr_i) && $stable(req_wdata_i)));

    a_r9_quiet_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_code_o == RSP_NONE) |-> (rsp_data_o == '0));

    a_r4_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_code_o inside {RSP_NONE, RSP_DATA, RSP_ERR});

endmodule

bind core_port_slave cp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_cmd_i    (req_cmd_i),
    .req_addr_i   (req_addr_i),
    .req_wdata_i  (req_wdata_i),
    .tgt_busy_i   (tgt_busy_i),
    .req_accept_o (req_accept_o),
    .rsp_code_o   (rsp_code_o),
    .rsp_data_o   (rsp_data_o)
);

// File: tb/core_port_slave_bench.sv
`timescale 1ns/1ps
module core_port_slave_bench;
    import cp_pkg::*;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 16;
    localparam int LAT    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cmd = CMD_IDLE;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              busy = 1'b0;
    logic              accept;
    logic [2:0]        rcode;
    logic [DATA_W-1:0] rdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic              exp_v [64];
    logic [2:0]        exp_c [64];
    logic [DATA_W-1:0] exp_d [64];
    logic [DATA_W-1:0] shadow [DEPTH];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    core_port_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .LAT(LAT)) u_core_port_slave (
        .clk_i(clk), .rst_ni(rst_n), .req_cmd_i(cmd), .req_addr_i(addr),
        .req_wdata_i(wdata), .tgt_busy_i(busy), .req_accept_o(accept),
        .rsp_code_o(rcode), .rsp_data_o(rdata)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Response monitor: exact cycle, order and data of every response (R4, R5, R6)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int idx;
            logic [2:0] ec;
            logic [DATA_W-1:0] ed;
            idx = cyc % 64;
            ec  = exp_v[idx] ? exp_c[idx] : RSP_NONE;
            ed  = exp_v[idx] ? exp_d[idx] : '0;
            if (exp_v[idx] || rcode != RSP_NONE) begin
                chk(rcode == ec, "R5", "response code in slot", DATA_W'(rcode), DATA_W'(ec));
                chk(rdata == ed, "R4", "response data in slot", rdata, ed);
            end
            exp_v[idx] = 1'b0;
        end
    end

    // One request; bp enables random busy deferral
    task automatic issue(input logic [2:0] c, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input bit bp);
        logic pb;
        int   slot;
        @(negedge clk);
        chk(accept == 1'b0, "R2", "accept low before new request", DATA_W'(accept), 0);
        cmd = c; addr = a; wdata = d;
        busy = bp ? 1'($urandom % 2) : 1'b0;
        pb = busy;
        forever begin
            @(negedge clk);
            chk(accept == !pb, "R2", "accept follows busy of previous edge", DATA_W'(accept), DATA_W'(!pb));
            if (accept) break;
            busy = bp ? 1'($urandom % 2) : 1'b0;
            pb = busy;
        end
        busy = 1'b0;
        if (c == CMD_READ) begin
            slot = (cyc + LAT) % 64;
            exp_v[slot] = 1'b1;
            exp_c[slot] = (a < DEPTH) ? RSP_DATA : RSP_ERR;
            exp_d[slot] = (a < DEPTH) ? shadow[a] : '0;
        end else if (c == CMD_WRITE && a < DEPTH) begin
            shadow[a] = d;
        end
    endtask

    task automatic go_idle(input int n, input string tag);
        @(negedge clk);
        cmd = CMD_IDLE; busy = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(accept == 1'b0, tag, "no accept while idle", DATA_W'(accept), 0);
            if (rcode == RSP_NONE)
                chk(rdata == '0, "R9", "data zero with no response", rdata, 0);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(accept == 1'b0, "R1", "accept in reset", DATA_W'(accept), 0);
        chk(rcode == RSP_NONE, "R1", "code in reset", DATA_W'(rcode), 0);
        chk(rdata == '0, "R1", "data in reset", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(accept == 1'b0 && rcode == RSP_NONE, "R1", "outputs after reset",
            DATA_W'({accept, rcode}), 0);
        issue(CMD_READ, 8'd5, '0, 1'b0);      // R1: cleared word reads 0
        go_idle(LAT + 2, "R1");
    endtask

    task automatic t_write_read;
        for (int i = 0; i < 4; i++)
            issue(CMD_WRITE, ADDR_W'(i * 3), 32'hA500_0000 + 32'(i), 1'b0);
        go_idle(LAT + 2, "R3");               // R3: posted writes give no response
        for (int i = 0; i < 4; i++)
            issue(CMD_READ, ADDR_W'(i * 3), '0, 1'b0);   // R4
        go_idle(LAT + 2, "R4");
    endtask

    task automatic t_order;
        issue(CMD_WRITE, 8'd1, 32'h1111_0001, 1'b0);
        issue(CMD_WRITE, 8'd2, 32'h2222_0002, 1'b0);
        issue(CMD_READ, 8'd2, '0, 1'b0);      // R5 back-to-back, distinct data
        issue(CMD_READ, 8'd1, '0, 1'b0);
        issue(CMD_READ, 8'd2, '0, 1'b0);
        issue(CMD_READ, 8'd9, '0, 1'b0);
        go_idle(LAT + 2, "R5");
    endtask

    task automatic t_unmapped;
        issue(CMD_READ, 8'd20, '0, 1'b0);                 // R6 error, zero data
        issue(CMD_READ, 8'd255, '0, 1'b0);
        issue(CMD_WRITE, 8'(DEPTH + 3), 32'hDEAD_BEEF, 1'b0); // R6 must not alias
        issue(CMD_READ, 8'd3, '0, 1'b0);
        go_idle(LAT + 2, "R6");
    endtask

    task automatic t_reserved;
        issue(CMD_WRITE, 8'd2, 32'h0BAD_0002, 1'b0);
        for (int c = 3; c < 8; c++)
            issue(3'(c), 8'd2, 32'hFFFF_0000 + 32'(c), 1'b0); // R7 accepted
        go_idle(LAT + 2, "R7");               // R7: no response
        issue(CMD_READ, 8'd2, '0, 1'b0);      // R7: word unchanged
        go_idle(LAT + 2, "R7");
    endtask

    task automatic t_backpressure;
        for (int i = 0; i < 60; i++) begin
            logic [ADDR_W-1:0] a;
            logic [2:0] c;
            a = ADDR_W'($urandom % (DEPTH + 4));
            c = ($urandom % 2 == 0) ? CMD_WRITE : CMD_READ;
            issue(c, a, $urandom, 1'b1);      // R8 deferred requests, R2 stalls
        end
        go_idle(LAT + 2, "R8");
        for (int i = 0; i < DEPTH; i++)
            issue(CMD_READ, ADDR_W'(i), '0, 1'b0);  // R8: each stalled write applied once
        go_idle(LAT + 2, "R8");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin exp_v[i] = 1'b0; exp_c[i] = '0; exp_d[i] = '0; end
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
        t_reset();
        t_write_read();
        t_order();
        t_unmapped();
        t_reserved();
        t_backpressure();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R2 watchdog expired actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule